// File: doc/BRIEF.md
# Message-Object Transfer Engine

This block sits between a host-visible set of interface registers and a 32-entry message-object store. The host first fills the interface halfwords: identifier filter mask, arbitration word, control word and four payload halfwords. It then writes a command byte. Writing an object number to the request register starts one transfer. The command byte decides the direction and which field groups travel. It also decides the side effects: clearing the pending flag, clearing the new-data flag, or setting the transmit request.

Every transfer is a read-modify-write of one object record, so fields that are not selected keep their old values. The protocol core shares the store with this block. A single grant input models that sharing: the engine only touches the store in cycles where the grant is high. Two 32-bit summary vectors mirror the pending and transmit-request flags of every object, with object n on bit n-1.

Top module: `msgif_xfer`

## Requirements
- R1: After synchronous reset, `xfer_busy` is 0, both summary vectors are 0, and every host register reads back as 0.
- R2: A host write of a value from 1 to 32 to address 0 starts a transfer. `xfer_busy` rises in the cycle after that write. Address 0 reads with bit 15 as busy and bits 5:0 as the accepted object number. With the grant held high, busy clears within 6 clock periods of the request write.
- R3: A request value of 0, or any value above 32, is dropped: busy does not rise.
- R4: Address 1 holds the command byte. When bit 7 is 1, the selected interface halfwords are copied into the object record and the unselected fields of the record keep their old contents. The group select bits are:
  - bit 6: mask halfwords (addresses 2, 3);
  - bit 5: arbitration halfwords (addresses 4, 5);
  - bit 4: control halfword (address 6);
  - bit 1: payload A (addresses 7, 8);
  - bit 0: payload B (addresses 9, 10).
- R5: With command bit 7 at 0, the selected record fields are copied into the interface halfwords. Unselected interface halfwords keep their contents. The control halfword that is returned shows the flags as they were before any clearing.
- R6: A store-to-host transfer with command bit 3 set clears control bit 13 (pending) in the record.
- R7: A store-to-host transfer with command bit 2 set clears control bit 15 (new data) in the record.
- R8: A host-to-store transfer with command bit 2 set sets control bit 8 (transmit request) in the record, even when the control group is not selected.
- R9: After each transfer of object n, bit n-1 of `intpnd_vec` equals record control bit 13 and bit n-1 of `txrqst_vec` equals record control bit 8.
- R10: A request written while busy is dropped: the running transfer and its object number are unaffected.
- R11: While `ram_gnt` is low the engine stalls without touching the store. Busy stays high, and the transfer completes within 6 cycles once the grant returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data for the address of the previous cycle |
| ram_gnt | input | 1 | Store access granted to this engine this cycle |
| xfer_busy | output | 1 | Transfer in progress |
| txrqst_vec | output | 32 | Transmit-request flag of object n on bit n-1 |
| intpnd_vec | output | 32 | Pending flag of object n on bit n-1 |

## Verification
The bench checks partial writes. It writes a full record, then overwrites only the arbitration and payload A groups. A whole-record write would destroy the mask and payload B contents that are read back afterwards. It checks that a control read with clearing returns the old flags while the store afterwards holds the cleared ones; a design that cleared before capture, or cleared the wrong bit, shows a wrong control halfword or a stale summary bit. The bench issues a transmit request without the control group, which catches a design that only honours bit 8 of the staged halfword. It also drops the grant and fires a second request during the stall. A design that ignores the grant, or accepts the second request, returns the wrong object's contents.

// File: rtl/msgif_pkg.sv
package msgif_pkg;

  localparam int unsigned HW  = 16;
  localparam int unsigned NHW = 9;

  // halfword slots of one object record
  localparam int unsigned HW_MASK_LO = 0;
  localparam int unsigned HW_MASK_HI = 1;
  localparam int unsigned HW_ARB_LO  = 2;
  localparam int unsigned HW_ARB_HI  = 3;
  localparam int unsigned HW_CTRL    = 4;
  localparam int unsigned HW_D0      = 5;

  // command byte bit positions
  localparam int unsigned CM_DIR    = 7;
  localparam int unsigned CM_MASK   = 6;
  localparam int unsigned CM_ARB    = 5;
  localparam int unsigned CM_CTRL   = 4;
  localparam int unsigned CM_CLRINT = 3;
  localparam int unsigned CM_TXNEW  = 2;
  localparam int unsigned CM_DA     = 1;
  localparam int unsigned CM_DB     = 0;

  // control halfword flag positions
  localparam int unsigned CT_NEWDAT = 15;
  localparam int unsigned CT_INTPND = 13;
  localparam int unsigned CT_TXRQ   = 8;

  typedef logic [NHW-1:0][HW-1:0] obj_t;

  typedef enum logic [1:0] {
    XS_IDLE,
    XS_FETCH,
    XS_STORE
  } xstate_t;

  function automatic int unsigned grp_bit(int unsigned slot);
    case (slot)
      0, 1:    return CM_MASK;
      2, 3:    return CM_ARB;
      4:       return CM_CTRL;
      5, 6:    return CM_DA;
      default: return CM_DB;
    endcase
  endfunction

endpackage

// File: rtl/msgobj_ram.sv
module msgobj_ram #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 144,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] q,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end

endmodule

// File: rtl/xfer_merge.sv
module xfer_merge
  import msgif_pkg::*;
(
  input  logic [7:0]     cmd,
  input  obj_t           ifc,
  input  obj_t           ram,
  output obj_t           ram_new,
  output logic [NHW-1:0] ifc_load
);

  obj_t base;

  for (genvar i = 0; i < NHW; i++) begin : g_slot
    localparam int unsigned GB = grp_bit(i);
    assign base[i]     = (cmd[CM_DIR] && cmd[GB]) ? ifc[i] : ram[i];
    assign ifc_load[i] = !cmd[CM_DIR] && cmd[GB];
  end

  always_comb begin
    ram_new = base;
    if (cmd[CM_DIR]) begin
      if (cmd[CM_TXNEW]) ram_new[HW_CTRL][CT_TXRQ] = 1'b1;
    end else begin
      if (cmd[CM_CLRINT]) ram_new[HW_CTRL][CT_INTPND] = 1'b0;
      if (cmd[CM_TXNEW])  ram_new[HW_CTRL][CT_NEWDAT] = 1'b0;
    end
  end

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import msgif_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned BUDGET  = 6,
  localparam int unsigned OBJ_W = $clog2(NUM_OBJ + 1),
  localparam int unsigned AW    = $clog2(NUM_OBJ),
  localparam int unsigned CW    = $clog2(BUDGET + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_we,
  input  logic [HW-1:0]    req_val,
  input  logic             gnt,
  output logic             busy,
  output logic             start,
  output logic [OBJ_W-1:0] obj_q,
  output logic             ram_re,
  output logic             ram_we,
  output logic [AW-1:0]    ram_addr
);

  xstate_t       state;
  logic          req_ok;
  logic [CW-1:0] gnt_cnt;

  assign req_ok   = (req_val != '0) && (req_val <= HW'(NUM_OBJ));
  assign busy     = (state != XS_IDLE);
  assign start    = req_we && req_ok && !busy;
  assign ram_re   = (state == XS_FETCH) && gnt;
  assign ram_we   = (state == XS_STORE) && gnt;
  assign ram_addr = AW'(obj_q - OBJ_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= XS_IDLE;
      obj_q <= '0;
    end else begin
      case (state)
        XS_IDLE: if (start) begin
          obj_q <= req_val[OBJ_W-1:0];
          state <= XS_FETCH;
        end
        XS_FETCH: if (gnt) state <= XS_STORE;
        XS_STORE: if (gnt) state <= XS_IDLE;
        default:  state <= XS_IDLE;
      endcase
    end
  end

  // cycles of a transfer during which the store was granted
  always_ff @(posedge clk) begin
    if (rst || !busy) gnt_cnt <= '0;
    else if (gnt && gnt_cnt != CW'(BUDGET)) gnt_cnt <= gnt_cnt + CW'(1);
  end

  AST_BUDGET: assert property (@(posedge clk) disable iff (rst)
    busy |-> (gnt_cnt < CW'(BUDGET))); // R2
  AST_BAD_OBJ: assert property (@(posedge clk) disable iff (rst)
    (req_we && !req_ok && !busy) |=> !busy); // R3
  AST_BUSY_IGN: assert property (@(posedge clk) disable iff (rst)
    (busy && req_we) |=> $stable(obj_q)); // R10
  AST_STALL: assert property (@(posedge clk) disable iff (rst)
    (busy && !gnt) |=> (busy && $stable(obj_q))); // R11

endmodule

// File: rtl/msgif_xfer.sv
module msgif_xfer
  import msgif_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned BUDGET  = 6,
  parameter int unsigned HAW     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic [HAW-1:0]     host_addr,
  input  logic [HW-1:0]      host_wdata,
  output logic [HW-1:0]      host_rdata,
  input  logic               ram_gnt,
  output logic               xfer_busy,
  output logic [NUM_OBJ-1:0] txrqst_vec,
  output logic [NUM_OBJ-1:0] intpnd_vec
);

  localparam int unsigned OBJ_W  = $clog2(NUM_OBJ + 1);
  localparam int unsigned AW     = $clog2(NUM_OBJ);
  localparam int unsigned W      = $bits(obj_t);
  localparam int unsigned A_REQ  = 0;
  localparam int unsigned A_CMD  = 1;
  localparam int unsigned A_IFC0 = 2;

  logic [7:0]       cmd_q, cmd_act;
  obj_t             ifc, ram_q, ram_new;
  logic [W-1:0]     ram_raw;
  logic [NHW-1:0]   ifc_load;
  logic [HW-1:0]    rd_mux;
  logic             start, ram_re, ram_we, req_we;
  logic [OBJ_W-1:0] obj_q;
  logic [AW-1:0]    ram_addr;

  assign req_we = host_we && (host_addr == HAW'(A_REQ));
  assign ram_q  = obj_t'(ram_raw);

  xfer_seq #(.NUM_OBJ(NUM_OBJ), .BUDGET(BUDGET)) u_seq (
    .clk(clk), .rst(rst), .req_we(req_we), .req_val(host_wdata), .gnt(ram_gnt),
    .busy(xfer_busy), .start(start), .obj_q(obj_q),
    .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr)
  );

  msgobj_ram #(.DEPTH(NUM_OBJ), .WIDTH(W)) u_ram (
    .clk(clk), .re(ram_re), .raddr(ram_addr), .q(ram_raw),
    .we(ram_we), .waddr(ram_addr), .wdata(W'(ram_new))
  );

  xfer_merge u_merge (
    .cmd(cmd_act), .ifc(ifc), .ram(ram_q), .ram_new(ram_new), .ifc_load(ifc_load)
  );

  always_comb begin
    rd_mux = '0;
    if (host_addr == HAW'(A_REQ))
      rd_mux = {xfer_busy, {(HW-1-OBJ_W){1'b0}}, obj_q};
    else if (host_addr == HAW'(A_CMD))
      rd_mux = {8'h00, cmd_q};
    for (int i = 0; i < NHW; i++)
      if (host_addr == HAW'(A_IFC0 + i)) rd_mux = ifc[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= '0;
      cmd_act    <= '0;
      ifc        <= '0;
      txrqst_vec <= '0;
      intpnd_vec <= '0;
      host_rdata <= '0;
    end else begin
      if (host_we && host_addr == HAW'(A_CMD)) cmd_q <= host_wdata[7:0];
      if (start) cmd_act <= cmd_q;
      for (int i = 0; i < NHW; i++) begin
        if (ram_we && ifc_load[i])
          ifc[i] <= ram_q[i];
        else if (host_we && host_addr == HAW'(A_IFC0 + i))
          ifc[i] <= host_wdata;
      end
      if (ram_we) begin
        intpnd_vec[ram_addr] <= ram_new[HW_CTRL][CT_INTPND];
        txrqst_vec[ram_addr] <= ram_new[HW_CTRL][CT_TXRQ];
      end
      host_rdata <= rd_mux;
    end
  end

  AST_CLR_PND: assert property (@(posedge clk) disable iff (rst)
    (ram_we && !cmd_act[CM_DIR] && cmd_act[CM_CLRINT]) |=> !intpnd_vec[ram_addr]); // R6
  AST_TX_SET: assert property (@(posedge clk) disable iff (rst)
    (ram_we && cmd_act[CM_DIR] && cmd_act[CM_TXNEW]) |=> txrqst_vec[ram_addr]); // R8
  AST_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !xfer_busy |=> $stable(intpnd_vec) && $stable(txrqst_vec)); // R11

endmodule

// File: tb/msgif_xfer_tb.sv
`timescale 1ns/100ps
module msgif_xfer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        ram_gnt = 1'b1;
  logic        xfer_busy;
  logic [31:0] txrqst_vec, intpnd_vec;

  int nchk = 0;
  int nfail = 0;

  logic [15:0] m_ram [32][9];
  logic [15:0] m_ifc [9];
  logic [31:0] m_int = '0;
  logic [31:0] m_tx  = '0;

  // {command byte, object number, pattern seed}
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {8'hF3, 8'd1,  8'hE5},
    {8'hF3, 8'd32, 8'h42},
    {8'hF3, 8'd9,  8'hA7},
    {8'hA2, 8'd9,  8'h3C},
    {8'h73, 8'd9,  8'h5A},
    {8'h84, 8'd32, 8'h99},
    {8'h13, 8'd32, 8'h11},
    {8'h18, 8'd1,  8'h66},
    {8'h10, 8'd1,  8'h77},
    {8'h14, 8'd1,  8'h88},
    {8'h10, 8'd1,  8'h2B},
    {8'h01, 8'd9,  8'hC4},
    {8'h40, 8'd32, 8'hD2}
  };

  always #2.5 clk = ~clk;

  msgif_xfer u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ram_gnt(ram_gnt),
    .xfer_busy(xfer_busy), .txrqst_vec(txrqst_vec), .intpnd_vec(intpnd_vec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    @(posedge clk); #1;
    d = host_rdata;
  endtask

  function automatic logic [15:0] pat(input logic [7:0] seed, input int k);
    return {seed, seed ^ 8'(k * 29)};
  endfunction

  function automatic logic selg(input logic [7:0] cmd, input int k);
    case (k)
      0, 1:    return cmd[6];
      2, 3:    return cmd[5];
      4:       return cmd[4];
      5, 6:    return cmd[1];
      default: return cmd[0];
    endcase
  endfunction

  // expected effect of one transfer, from the requirements
  task automatic model(input logic [7:0] cmd, input int obj);
    int o = obj - 1;
    if (cmd[7]) begin
      for (int k = 0; k < 9; k++) if (selg(cmd, k)) m_ram[o][k] = m_ifc[k];
      if (cmd[2]) m_ram[o][4][8] = 1'b1;
    end else begin
      for (int k = 0; k < 9; k++) if (selg(cmd, k)) m_ifc[k] = m_ram[o][k];
      if (cmd[3]) m_ram[o][4][13] = 1'b0;
      if (cmd[2]) m_ram[o][4][15] = 1'b0;
    end
    m_int[o] = m_ram[o][4][13];
    m_tx[o]  = m_ram[o][4][8];
  endtask

  task automatic load_ifc(input logic [7:0] seed);
    for (int k = 0; k < 9; k++) begin
      wr(4'(2 + k), pat(seed, k));
      m_ifc[k] = pat(seed, k);
    end
  endtask

  task automatic cmp_ifc(input string tag);
    logic [15:0] d;
    for (int k = 0; k < 9; k++) begin
      rd(4'(2 + k), d);
      chk(tag, {16'h0, d}, {16'h0, m_ifc[k]});
    end
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int n;
    for (int k = 0; k < 9; k++) m_ifc[k] = '0;
    for (int o = 0; o < 32; o++) for (int k = 0; k < 9; k++) m_ram[o][k] = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk("R1 busy", {31'h0, xfer_busy}, 32'h0);
    chk("R1 intpnd", intpnd_vec, 32'h0);
    chk("R1 txrqst", txrqst_vec, 32'h0);
    rd(4'd6, d); chk("R1 ctrl reg", {16'h0, d}, 32'h0);
    rd(4'd0, d); chk("R1 req reg", {16'h0, d}, 32'h0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [7:0] cmd;
      logic [7:0] obj;
      string tag;
      cmd = VEC[v][23:16];
      obj = VEC[v][15:8];
      load_ifc(VEC[v][7:0]);
      wr(4'd1, {8'h00, cmd});
      wr(4'd0, {8'h00, obj});
      chk("R2 busy rise", {31'h0, xfer_busy}, 32'h1);
      n = 0;
      while (xfer_busy && n < 50) begin
        @(posedge clk); #1; n++;
      end
      chk("R2 budget", {31'h0, (n >= 1 && n <= 6)}, 32'h1);
      model(cmd, int'(obj));
      if (cmd[7])      tag = cmd[2] ? "R8" : "R4";
      else if (cmd[3]) tag = "R6";
      else if (cmd[2]) tag = "R7";
      else             tag = "R5 R4";
      cmp_ifc(tag);
      chk("R9 intpnd", intpnd_vec, m_int);
      chk("R9 txrqst", txrqst_vec, m_tx);
    end

    // R3 out-of-range object numbers
    wr(4'd0, 16'd0);
    chk("R3 zero", {31'h0, xfer_busy}, 32'h0);
    wr(4'd0, 16'd33);
    chk("R3 above", {31'h0, xfer_busy}, 32'h0);
    rd(4'd0, d); chk("R3 busy bit", {31'h0, d[15]}, 32'h0);

    // R11 stall without grant, R10 request while busy
    load_ifc(8'h3E);
    wr(4'd1, 16'h0073);
    @(negedge clk) ram_gnt = 1'b0;
    wr(4'd0, 16'd9);
    repeat (10) @(posedge clk);
    #1 chk("R11 stalled", {31'h0, xfer_busy}, 32'h1);
    rd(4'd0, d); chk("R2 busy readback", {16'h0, d}, 32'h8009);
    wr(4'd0, 16'd32);
    @(negedge clk) ram_gnt = 1'b1;
    n = 0;
    while (xfer_busy && n < 50) begin
      @(posedge clk); #1; n++;
    end
    chk("R11 resume", {31'h0, (n >= 1 && n <= 6)}, 32'h1);
    model(8'h73, 9);
    cmp_ifc("R10");
    rd(4'd0, d); chk("R10 object kept", {16'h0, d}, 32'h0009);
    chk("R10 no restart", {31'h0, xfer_busy}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule